// File: doc/BRIEF.md
# Offset-Adjusted Compare Timer Channel

This block is one compare channel of a 64-bit system timer. A free-running system counter comes in from outside. The channel forms a view of that count: either the raw count (physical variant) or the count minus a programmable 64-bit offset (virtual variant, chosen by a parameter). It compares that view against a 64-bit compare value. The result is a status flag held in the control register and a level interrupt.

Software uses a simple register port with one write per cycle. The four selectable registers are control, compare value, a 32-bit signed timer-value window, and the offset. The timer-value window is relative to the adjusted count. Reading it gives the distance left to the deadline. Writing it arms a deadline that distance ahead of the adjusted count. A read-only port also shows the adjusted count at all times.

Top module: `vtc_top`

## Requirements
- R1: `vcount` always equals `sys_cnt` minus the offset register, modulo 2^64.
- R2: At every clock edge outside reset, status (control bit 2) is loaded with enable AND ((`sys_cnt` − offset) ≥ compare value). The comparison is unsigned 64-bit and uses the register values that result from any write at that same edge.
- R3: Status is 0 while enable (control bit 0) is 0, whatever the counter and compare value are.
- R4: `irq` is 1 exactly when status is 1 and the mask bit (control bit 1) is 0.
- R5: A read with select 2 (timer value) returns, zero-extended, the low 32 bits of compare value − (`sys_cnt` − offset).
- R6: A write with select 2 sets the compare value to (`sys_cnt` − offset) plus `wr_data[31:0]` sign-extended to 64 bits.
- R7: A write with select 3 loads the offset, and status is re-evaluated with the new offset at that same edge.
- R8: Reset (synchronous, `rst_n` low) clears the offset, the compare value and the control register, so `irq` is 0 after reset.
- R9: A write with select 0 loads enable from bit 0 and mask from bit 1. Bit 2 of the written data has no effect on status.
- R10: The adjusted count wraps. When the offset exceeds the counter, the view is a large unsigned value, and status follows that unsigned value.
- R11: Select 1 reads and writes the compare value as a full 64-bit word. Select 3 reads the offset. Control reads as {61'b0, status, mask, enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 control, 1 compare, 2 timer value, 3 offset |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 64 | Combinational read data |
| vcount | output | 64 | Offset-adjusted count |
| irq | output | 1 | Level interrupt |

## Verification
A counter stepping by one across the deadline shows that the comparison is greater-or-equal and not strictly greater. Deadlines set through the timer-value window with positive and negative 32-bit values separate a correct sign extension from zero extension. Offset writes that push the adjusted count back below the compare value, and an offset larger than the counter, separate same-edge re-evaluation and unsigned wrap from stale or signed comparison. Writing control with bit 2 set, and toggling enable and mask, separate read-only status and interrupt gating from plain register echo.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int CNT_W = 64;
  localparam int TV_W  = 32;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_TVAL = 2'd2,
    SEL_OFF  = 2'd3
  } vtc_sel_e;

  // adjusted count, wraps modulo 2^CNT_W
  function automatic logic [CNT_W-1:0] view_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] off);
    return cnt - off;
  endfunction

  // unsigned deadline test
  function automatic logic reached(input logic [CNT_W-1:0] view,
                                   input logic [CNT_W-1:0] cmp);
    return view >= cmp;
  endfunction

  function automatic logic [TV_W-1:0] tval_of(input logic [CNT_W-1:0] cmp,
                                              input logic [CNT_W-1:0] view);
    logic [CNT_W-1:0] diff;
    diff = cmp - view;
    return diff[TV_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] cmp_from_tval(input logic [CNT_W-1:0] view,
                                                     input logic [TV_W-1:0]  tv);
    return view + {{(CNT_W-TV_W){tv[TV_W-1]}}, tv};
  endfunction
endpackage

// File: rtl/vtc_regs.sv
module vtc_regs
  import vtc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int TW = TV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] view_now,
  output logic          en_q,
  output logic          mask_q,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] off_q,
  output logic          en_nxt,
  output logic [CW-1:0] cmp_nxt,
  output logic [CW-1:0] off_nxt
);
  logic mask_nxt;
  logic wr_ctl, wr_cmp, wr_tv, wr_off;

  assign wr_ctl = wr_en && (vtc_sel_e'(wr_sel) == SEL_CTL);
  assign wr_cmp = wr_en && (vtc_sel_e'(wr_sel) == SEL_CMP);
  assign wr_tv  = wr_en && (vtc_sel_e'(wr_sel) == SEL_TVAL);
  assign wr_off = wr_en && (vtc_sel_e'(wr_sel) == SEL_OFF);

  always_comb begin
    en_nxt   = wr_ctl ? wr_data[0] : en_q;
    mask_nxt = wr_ctl ? wr_data[1] : mask_q;
    off_nxt  = wr_off ? wr_data : off_q;
    if (wr_cmp)     cmp_nxt = wr_data;
    else if (wr_tv) cmp_nxt = cmp_from_tval(view_now, wr_data[TW-1:0]);
    else            cmp_nxt = cmp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '0;
      off_q  <= '0;
    end else begin
      en_q   <= en_nxt;
      mask_q <= mask_nxt;
      cmp_q  <= cmp_nxt;
      off_q  <= off_nxt;
    end
  end

  // R9: control write takes enable/mask from bits 0/1
  p_ctl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (en_q == $past(wr_data[0])) && (mask_q == $past(wr_data[1])));

  // R6: timer-value write lands adjusted count plus signed delta
  p_tval_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tv |=> (cmp_q - $past(view_now)) ==
              {{(CW-TW){$past(wr_data[TW-1])}}, $past(wr_data[TW-1:0])});
endmodule

// File: rtl/vtc_status.sv
module vtc_status
  import vtc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sys_cnt,
  input  logic          en_nxt,
  input  logic [CW-1:0] cmp_nxt,
  input  logic [CW-1:0] off_nxt,
  input  logic          en_q,
  output logic          status_q,
  output logic          hit_nxt
);
  assign hit_nxt = reached(view_count(sys_cnt, off_nxt), cmp_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= en_nxt && hit_nxt;
  end

  // R3: no status while the channel is off
  p_status_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> en_q);
endmodule

// File: rtl/vtc_top.sv
module vtc_top
  import vtc_pkg::*;
#(
  parameter int CW        = CNT_W,
  parameter int TW        = TV_W,
  parameter bit VIRT_VIEW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sys_cnt,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [CW-1:0] rd_data,
  output logic [CW-1:0] vcount,
  output logic          irq
);
  logic          en_q, mask_q, en_nxt, status_q, hit_nxt;
  logic [CW-1:0] cmp_q, off_q, cmp_nxt, off_nxt;
  logic [CW-1:0] off_eff, off_nxt_eff, view_now;
  logic          off_write;

  generate
    if (VIRT_VIEW) begin : g_virt
      assign off_eff     = off_q;
      assign off_nxt_eff = off_nxt;
    end else begin : g_phys
      assign off_eff     = '0;
      assign off_nxt_eff = '0;
    end
  endgenerate

  assign view_now  = view_count(sys_cnt, off_eff);
  assign vcount    = view_now;
  assign off_write = wr_en && (vtc_sel_e'(wr_sel) == SEL_OFF);

  vtc_regs #(.CW(CW), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .view_now(view_now), .en_q(en_q), .mask_q(mask_q), .cmp_q(cmp_q),
    .off_q(off_q), .en_nxt(en_nxt), .cmp_nxt(cmp_nxt), .off_nxt(off_nxt)
  );

  vtc_status #(.CW(CW)) u_status (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .en_nxt(en_nxt),
    .cmp_nxt(cmp_nxt), .off_nxt(off_nxt_eff), .en_q(en_q),
    .status_q(status_q), .hit_nxt(hit_nxt)
  );

  assign irq = status_q && !mask_q;

  always_comb begin
    unique case (vtc_sel_e'(rd_sel))
      SEL_CTL:  rd_data = {{(CW-3){1'b0}}, status_q, mask_q, en_q};
      SEL_CMP:  rd_data = cmp_q;
      SEL_TVAL: rd_data = {{(CW-TW){1'b0}}, tval_of(cmp_q, view_now)};
      default:  rd_data = off_eff;
    endcase
  end

  // R4: interrupt only from an enabled channel
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q);

  // R7: offset write re-evaluates at the same edge
  p_off_reeval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    off_write |=> status_q == (en_q && ($past(sys_cnt) - off_eff >= cmp_q)));
endmodule

// File: tb/vtc_top_tb_top.sv
module vtc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data, vcount;
  logic        irq;

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  bit edge_seen = 0;

  // reference model state
  logic        m_en = 0, m_mk = 0, m_st = 0;
  logic [63:0] m_cmp = '0, m_off = '0;

  always #10 clk = ~clk;  // 50 MHz

  vtc_top dut_i (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .vcount(vcount), .irq(irq)
  );

  always @(posedge clk) begin
    logic [63:0] n_cmp_v, n_off_v, adj;
    logic [64:0] d;
    logic        n_en, n_mk;
    edge_seen <= 1;
    if (!rst_n) begin
      m_en <= 0; m_mk <= 0; m_st <= 0; m_cmp <= '0; m_off <= '0;
    end else begin
      n_en = m_en; n_mk = m_mk; n_cmp_v = m_cmp; n_off_v = m_off;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin n_en = wr_data[0]; n_mk = wr_data[1]; end
          2'd1: n_cmp_v = wr_data;
          2'd2: n_cmp_v = sys_cnt - m_off + 64'(signed'(wr_data[31:0]));
          default: n_off_v = wr_data;
        endcase
      end
      adj = sys_cnt - n_off_v;
      d = {1'b0, adj} - {1'b0, n_cmp_v};
      m_en <= n_en; m_mk <= n_mk; m_cmp <= n_cmp_v; m_off <= n_off_v;
      m_st <= n_en & ~d[64];
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [63:0] e;
    cyc_n++;
    if (edge_seen) begin
      chk({63'b0, irq}, {63'b0, m_st & ~m_mk}, "R4/R8 irq");
      chk(vcount, sys_cnt - m_off, "R1/R10 vcount");
      case (rd_sel)
        2'd0: chk(rd_data, {61'b0, m_st, m_mk, m_en}, "R2/R3/R8/R9/R11 ctl");
        2'd1: chk(rd_data, m_cmp, "R6/R11 cmp");
        2'd2: begin e = m_cmp + m_off - sys_cnt; chk(rd_data, {32'b0, e[31:0]}, "R5 tval"); end
        default: chk(rd_data, m_off, "R7/R8 off");
      endcase
    end
    if (cyc_n > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc_n);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(input bit we, input logic [1:0] ws, input logic [63:0] wd,
                      input logic [63:0] c, input logic [1:0] rs);
    @(negedge clk); #1;
    wr_en = we; wr_sel = ws; wr_data = wd; sys_cnt = c; rd_sel = rs;
  endtask

  task automatic idle(input logic [63:0] c, input logic [1:0] rs);
    step(0, 2'd0, '0, c, rs);
  endtask

  initial begin
    logic [63:0] c;
    c = 64'd1000;
    // R8: reset
    for (int i = 0; i < 3; i++) idle(c, 2'(i));
    step(0, 0, 0, c, 0); rst_n = 1;
    for (int i = 0; i < 4; i++) idle(c, 2'(i));
    // R7/R1: offset
    step(1, 3, 64'd100, c, 3);
    idle(c, 3); idle(c, 1);
    // R11: compare, R9: enable
    step(1, 1, 64'd950, c, 1);
    step(1, 0, 64'd1, c, 0);
    // R2: step across deadline at adjusted 950
    for (int i = 0; i < 60; i++) begin c = c + 1; idle(c, 2'(i % 3)); end
    // R4: mask
    step(1, 0, 64'd3, c, 0); idle(c, 0);
    step(1, 0, 64'd1, c, 0); idle(c, 0);
    // R7: bigger offset drops status at once
    step(1, 3, 64'd500, c, 0); idle(c, 0); idle(c, 2);
    // R9: write bit2 with condition false
    step(1, 0, 64'd7, c, 0); idle(c, 0);
    step(1, 0, 64'd1, c, 0);
    // R6/R5: negative and positive timer-value writes
    step(1, 2, 64'hFFFF_FFFF_FFFF_FFF0, c, 2); idle(c, 1); idle(c, 0);
    step(1, 2, 64'h0000_0000_0000_0010, c, 2);
    for (int i = 0; i < 20; i++) begin c = c + 1; idle(c, 2'(i % 4)); end
    step(1, 2, 64'h0000_0000_8000_0000, c, 1); idle(c, 2); idle(c, 0);
    // R3: disable with condition true
    step(1, 2, 64'h0000_0000_FFFF_FFFE, c, 0); idle(c, 0);
    step(1, 0, 64'd0, c, 0); idle(c, 0);
    // R10: offset above counter wraps to large view
    c = 64'd5;
    step(1, 1, 64'd1000, c, 1);
    step(1, 0, 64'd1, c, 0);
    step(1, 3, 64'd10, c, 0); idle(c, 0); idle(c, 2);
    step(1, 3, 64'd0, c, 0); idle(c, 0);
    // R8: reset again
    step(0, 0, 0, c, 0); rst_n = 0; idle(c, 3); idle(c, 1);
    step(0, 0, 0, c, 0); rst_n = 1; idle(c, 0); idle(c, 3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule